// File: doc/BRIEF.md
# Indexed Configuration Register Space

This block is the plug-and-play configuration space of a multi-function I/O controller. A host reaches it through a window of two bytes. A write to byte 0 latches a register index. A read or write of byte 1 then acts on the register named by that index. A few registers are global: a chip identifier, a revision number and a selector for the current logical device. The registers from index 0x30 upward are banked. The same index reaches the storage of whichever logical device the selector names.

Each logical device has an activate bit and a 16-bit I/O base address. The block exports every device's enable flag and base address. A small runtime decoder compares incoming runtime I/O addresses against the 16-byte window of every active device. It reports a hit together with the number of the claiming device.

Top module: `cfg_space_top`

## Requirements
- R1: A host write to offset 0 (host_addr=0) latches host_wdata as the index. A host read of offset 0 returns the latched index.
- R2: Index 0x20 reads 0xE9 (parameter CHIP_ID). Writes to it have no effect on any register.
- R3: Index 0x27 reads the revision parameter REV_ID (default 0x01). Writes to it have no effect.
- R4: Index 0x07 holds the logical-device selector. A written value from 0 to NDEV-1 (0x00..0x0E by default) is stored. A written value of NDEV or more is ignored. A read returns the selector in the low bits and zero above them.
- R5: Index 0x30 is banked by the selector. Bit 0 of a write sets or clears the activate flag of the selected device only. A read returns that flag in bit 0 and zero in bits 7:1.
- R6: Index 0x60 holds bits 15:8 and index 0x61 holds bits 7:0 of the selected device's base address. Both are banked per device, and other devices are untouched.
- R7: A read of any other index returns 0x00.
- R8: Synchronous reset clears the index, the selector, every activate flag, every base address, host_rdata and the runtime hit output.
- R9: Read data appears on host_rdata on the clock edge that samples the read strobe. It holds its value until the next read. Accesses with host_cs low change nothing.
- R10: dev_en[d] and dev_base[16*d+:16] show device d's stored flag and base from the clock edge of the configuring write onward.
- R11: A runtime access (rt_valid) is reported one cycle later on rt_hit. rt_hit is set when rt_addr[15:4] equals base[15:4] of an active device. rt_dev gives the lowest-numbered such device. Inactive devices never claim.
- R12: A runtime access sampled in the same cycle as a configuration write is decoded against the configuration as it stood before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_cs | input | 1 | Host access strobe for the two-byte window |
| host_wr | input | 1 | Host write |
| host_rd | input | 1 | Host read |
| host_addr | input | 1 | Window byte: 0 index, 1 data |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Registered host read data |
| rt_valid | input | 1 | Runtime I/O access present |
| rt_addr | input | 16 | Runtime I/O address |
| rt_hit | output | 1 | Registered: the access falls in an active device window |
| rt_dev | output | 4 | Registered number of the claiming device |
| dev_en | output | NDEV | Per-device enable flags |
| dev_base | output | 16*NDEV | Per-device base addresses, device d at bits 16*d+15:16*d |

## Verification
A configuration write that moves or deactivates a device and a runtime access to that device's window can fall in the same clock cycle. The bench drives both on one edge: it clears the activate flag of a device while probing an address inside that device's window. It expects a hit by the old owner. A second probe on the next cycle must then miss. The random phase mixes base and activate writes with probes and reaches the same overlap by chance. Every result is judged against a bench model that applies a write only after decoding the probe of the same cycle.

// File: rtl/cfg_space_pkg.sv
package cfg_space_pkg;

  localparam logic [7:0] IDX_SELECT  = 8'h07;
  localparam logic [7:0] IDX_CHIPID  = 8'h20;
  localparam logic [7:0] IDX_REVNUM  = 8'h27;
  localparam logic [7:0] IDX_ACTIVE  = 8'h30;
  localparam logic [7:0] IDX_BASE_HI = 8'h60;
  localparam logic [7:0] IDX_BASE_LO = 8'h61;

  localparam int BASE_W = 16;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_DEVSEL,
    SEL_CHIPID,
    SEL_REVNUM,
    SEL_ACTIVE,
    SEL_BASE_HI,
    SEL_BASE_LO
  } reg_sel_e;

  function automatic reg_sel_e decode_index(input logic [7:0] idx);
    reg_sel_e s;
    case (idx)
      IDX_SELECT:  s = SEL_DEVSEL;
      IDX_CHIPID:  s = SEL_CHIPID;
      IDX_REVNUM:  s = SEL_REVNUM;
      IDX_ACTIVE:  s = SEL_ACTIVE;
      IDX_BASE_HI: s = SEL_BASE_HI;
      IDX_BASE_LO: s = SEL_BASE_LO;
      default:     s = SEL_NONE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/cfg_host_port.sv
module cfg_host_port
  import cfg_space_pkg::*;
#(
  parameter int         NDEV    = 15,
  parameter logic [7:0] CHIP_ID = 8'hE9,
  parameter logic [7:0] REV_ID  = 8'h01,
  localparam int        LDN_W   = (NDEV > 1) ? $clog2(NDEV) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_cs,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic              host_addr,
  input  logic [7:0]        host_wdata,
  input  logic              sel_active,
  input  logic [BASE_W-1:0] sel_base,
  output logic [7:0]        host_rdata,
  output logic [LDN_W-1:0]  cur_dev,
  output logic              we_active,
  output logic              we_base_hi,
  output logic              we_base_lo
);

  logic [7:0]  index_q;
  logic [7:0]  rd_mux;
  reg_sel_e    sel;
  logic        wr_index;
  logic        wr_data;
  logic        rd_any;
  logic        devsel_ok;

  assign sel       = decode_index(index_q);
  assign wr_index  = host_cs && host_wr && !host_addr;
  assign wr_data   = host_cs && host_wr &&  host_addr;
  assign rd_any    = host_cs && host_rd;
  assign devsel_ok = (host_wdata < 8'(NDEV));

  assign we_active  = wr_data && (sel == SEL_ACTIVE);
  assign we_base_hi = wr_data && (sel == SEL_BASE_HI);
  assign we_base_lo = wr_data && (sel == SEL_BASE_LO);

  always_comb begin
    rd_mux = 8'h00;
    case (sel)
      SEL_DEVSEL:  rd_mux = 8'(cur_dev);
      SEL_CHIPID:  rd_mux = CHIP_ID;
      SEL_REVNUM:  rd_mux = REV_ID;
      SEL_ACTIVE:  rd_mux = {7'b0, sel_active};
      SEL_BASE_HI: rd_mux = sel_base[15:8];
      SEL_BASE_LO: rd_mux = sel_base[7:0];
      default:     rd_mux = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      index_q    <= 8'h00;
      cur_dev    <= '0;
      host_rdata <= 8'h00;
    end else begin
      if (wr_index)
        index_q <= host_wdata;
      if (wr_data && (sel == SEL_DEVSEL) && devsel_ok)
        cur_dev <= host_wdata[LDN_W-1:0];
      if (rd_any)
        host_rdata <= host_addr ? rd_mux : index_q;
    end
  end

endmodule

// File: rtl/cfg_dev_bank.sv
module cfg_dev_bank
  import cfg_space_pkg::*;
#(
  parameter int  NDEV  = 15,
  localparam int LDN_W = (NDEV > 1) ? $clog2(NDEV) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [LDN_W-1:0]       cur_dev,
  input  logic                   we_active,
  input  logic                   we_base_hi,
  input  logic                   we_base_lo,
  input  logic [7:0]             wdata,
  output logic [NDEV-1:0]        dev_en,
  output logic [NDEV*BASE_W-1:0] dev_base,
  output logic                   sel_active,
  output logic [BASE_W-1:0]      sel_base
);

  for (genvar g = 0; g < NDEV; g++) begin : g_dev
    logic              hit_sel;
    logic              act_q;
    logic [BASE_W-1:0] base_q;

    assign hit_sel = (cur_dev == LDN_W'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        act_q  <= 1'b0;
        base_q <= '0;
      end else if (hit_sel) begin
        if (we_active)
          act_q <= wdata[0];
        if (we_base_hi)
          base_q[15:8] <= wdata;
        if (we_base_lo)
          base_q[7:0] <= wdata;
      end
    end

    assign dev_en[g]                   = act_q;
    assign dev_base[g*BASE_W +: BASE_W] = base_q;
  end

  always_comb begin
    sel_active = 1'b0;
    sel_base   = '0;
    for (int i = 0; i < NDEV; i++) begin
      if (cur_dev == LDN_W'(i)) begin
        sel_active = dev_en[i];
        sel_base   = dev_base[i*BASE_W +: BASE_W];
      end
    end
  end

endmodule

// File: rtl/cfg_rt_decoder.sv
module cfg_rt_decoder
  import cfg_space_pkg::*;
#(
  parameter int  NDEV     = 15,
  parameter int  WIN_BITS = 4,
  localparam int LDN_W    = (NDEV > 1) ? $clog2(NDEV) : 1,
  localparam int TAG_W    = BASE_W - WIN_BITS
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   rt_valid,
  input  logic [BASE_W-1:0]      rt_addr,
  input  logic [NDEV-1:0]        dev_en,
  input  logic [NDEV*BASE_W-1:0] dev_base,
  output logic                   rt_hit,
  output logic [LDN_W-1:0]       rt_dev
);

  logic [NDEV-1:0]  match;
  logic             any_match;
  logic [LDN_W-1:0] first_dev;

  for (genvar g = 0; g < NDEV; g++) begin : g_cmp
    assign match[g] = dev_en[g] &&
      (rt_addr[BASE_W-1:WIN_BITS] == dev_base[g*BASE_W+WIN_BITS +: TAG_W]);
  end

  always_comb begin
    any_match = |match;
    first_dev = '0;
    for (int i = NDEV - 1; i >= 0; i--) begin
      if (match[i])
        first_dev = LDN_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rt_hit <= 1'b0;
      rt_dev <= '0;
    end else begin
      rt_hit <= rt_valid && any_match;
      if (rt_valid && any_match)
        rt_dev <= first_dev;
    end
  end

endmodule

// File: rtl/cfg_space_top.sv
module cfg_space_top
  import cfg_space_pkg::*;
#(
  parameter int         NDEV     = 15,
  parameter int         WIN_BITS = 4,
  parameter logic [7:0] CHIP_ID  = 8'hE9,
  parameter logic [7:0] REV_ID   = 8'h01,
  localparam int        LDN_W    = (NDEV > 1) ? $clog2(NDEV) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   host_cs,
  input  logic                   host_wr,
  input  logic                   host_rd,
  input  logic                   host_addr,
  input  logic [7:0]             host_wdata,
  output logic [7:0]             host_rdata,
  input  logic                   rt_valid,
  input  logic [15:0]            rt_addr,
  output logic                   rt_hit,
  output logic [LDN_W-1:0]       rt_dev,
  output logic [NDEV-1:0]        dev_en,
  output logic [NDEV*16-1:0]     dev_base
);

  logic [LDN_W-1:0]  cur_dev;
  logic              we_active;
  logic              we_base_hi;
  logic              we_base_lo;
  logic              sel_active;
  logic [BASE_W-1:0] sel_base;

  cfg_host_port #(
    .NDEV    (NDEV),
    .CHIP_ID (CHIP_ID),
    .REV_ID  (REV_ID)
  ) u_port (
    .clk        (clk),
    .rst        (rst),
    .host_cs    (host_cs),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .sel_active (sel_active),
    .sel_base   (sel_base),
    .host_rdata (host_rdata),
    .cur_dev    (cur_dev),
    .we_active  (we_active),
    .we_base_hi (we_base_hi),
    .we_base_lo (we_base_lo)
  );

  cfg_dev_bank #(
    .NDEV (NDEV)
  ) u_bank (
    .clk        (clk),
    .rst        (rst),
    .cur_dev    (cur_dev),
    .we_active  (we_active),
    .we_base_hi (we_base_hi),
    .we_base_lo (we_base_lo),
    .wdata      (host_wdata),
    .dev_en     (dev_en),
    .dev_base   (dev_base),
    .sel_active (sel_active),
    .sel_base   (sel_base)
  );

  cfg_rt_decoder #(
    .NDEV     (NDEV),
    .WIN_BITS (WIN_BITS)
  ) u_rt (
    .clk      (clk),
    .rst      (rst),
    .rt_valid (rt_valid),
    .rt_addr  (rt_addr),
    .dev_en   (dev_en),
    .dev_base (dev_base),
    .rt_hit   (rt_hit),
    .rt_dev   (rt_dev)
  );

endmodule

// File: rtl/cfg_space_chk.sv
module cfg_space_chk #(
  parameter int  NDEV  = 15,
  localparam int LDN_W = (NDEV > 1) ? $clog2(NDEV) : 1
) (
  input logic               clk,
  input logic               rst,
  input logic               host_cs,
  input logic               host_wr,
  input logic               host_rd,
  input logic [7:0]         host_rdata,
  input logic               rt_valid,
  input logic               rt_hit,
  input logic [LDN_W-1:0]   rt_dev,
  input logic [NDEV-1:0]    dev_en,
  input logic [NDEV*16-1:0] dev_base
);

  // R9
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(host_cs && host_rd) |=> $stable(host_rdata));

  // R10
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(host_cs && host_wr) |=> ($stable(dev_en) && $stable(dev_base)));

  // R11
  hit_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
    !rt_valid |=> !rt_hit);

  // R11
  hit_owner_active_chk: assert property (@(posedge clk) disable iff (rst)
    rt_hit |-> ((($past(dev_en) >> rt_dev) & NDEV'(1)) != '0));

  // R11
  hit_dev_range_chk: assert property (@(posedge clk) disable iff (rst)
    rt_hit |-> (32'(rt_dev) < NDEV));

  // R8
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (dev_en == '0 && dev_base == '0 && !rt_hit && host_rdata == 8'h00));

endmodule

bind cfg_space_top cfg_space_chk #(.NDEV(NDEV)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .host_cs    (host_cs),
  .host_wr    (host_wr),
  .host_rd    (host_rd),
  .host_rdata (host_rdata),
  .rt_valid   (rt_valid),
  .rt_hit     (rt_hit),
  .rt_dev     (rt_dev),
  .dev_en     (dev_en),
  .dev_base   (dev_base)
);

// File: tb/sim_cfg_space_top.sv
`timescale 1ns/1ps
module sim_cfg_space_top;

  localparam int NDEV = 15;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              host_cs = 1'b0, host_wr = 1'b0, host_rd = 1'b0, host_addr = 1'b0;
  logic [7:0]        host_wdata = 8'h00;
  logic [7:0]        host_rdata;
  logic              rt_valid = 1'b0;
  logic [15:0]       rt_addr = 16'h0000;
  logic              rt_hit;
  logic [3:0]        rt_dev;
  logic [NDEV-1:0]   dev_en;
  logic [NDEV*16-1:0] dev_base;

  always #5 clk = ~clk;

  cfg_space_top u0 (
    .clk(clk), .rst(rst), .host_cs(host_cs), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .rt_valid(rt_valid), .rt_addr(rt_addr), .rt_hit(rt_hit), .rt_dev(rt_dev),
    .dev_en(dev_en), .dev_base(dev_base)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // bench model
  logic [7:0]  m_idx;
  logic [3:0]  m_dev;
  logic        m_act [NDEV];
  logic [15:0] m_base [NDEV];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(input logic [7:0] idx);
    case (idx)
      8'h07: return {4'b0, m_dev};
      8'h20: return 8'hE9;
      8'h27: return 8'h01;
      8'h30: return {7'b0, m_act[m_dev]};
      8'h60: return m_base[m_dev][15:8];
      8'h61: return m_base[m_dev][7:0];
      default: return 8'h00;
    endcase
  endfunction

  function automatic void model_write(input logic [7:0] d);
    case (m_idx)
      8'h07: if (d < NDEV) m_dev = d[3:0];
      8'h30: m_act[m_dev] = d[0];
      8'h60: m_base[m_dev][15:8] = d;
      8'h61: m_base[m_dev][7:0] = d;
      default: ;
    endcase
  endfunction

  function automatic logic [4:0] exp_rt(input logic [15:0] a);
    for (int d = 0; d < NDEV; d++)
      if (m_act[d] && m_base[d][15:4] == a[15:4]) return {1'b1, 4'(d)};
    return 5'b0;
  endfunction

  task automatic host_write(input logic a, input logic [7:0] d);
    @(negedge clk);
    host_cs = 1; host_wr = 1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_cs = 0; host_wr = 0;
    if (a == 0) m_idx = d; else model_write(d);
  endtask

  task automatic host_read(input logic a, output logic [7:0] v);
    @(negedge clk);
    host_cs = 1; host_rd = 1; host_addr = a;
    @(negedge clk);
    host_cs = 0; host_rd = 0;
    v = host_rdata;
  endtask

  task automatic reg_write(input logic [7:0] idx, input logic [7:0] d);
    host_write(0, idx);
    host_write(1, d);
  endtask

  task automatic reg_check(input string req, input logic [7:0] idx);
    logic [7:0] v;
    host_write(0, idx);
    host_read(1, v);
    chk(req, v, exp_read(idx));
  endtask

  task automatic probe(input string req, input logic [15:0] a);
    logic [4:0] e;
    e = exp_rt(a);
    @(negedge clk);
    rt_valid = 1; rt_addr = a;
    @(negedge clk);
    rt_valid = 0;
    chk(req, {rt_hit, rt_hit ? rt_dev : 4'h0}, {e[4], e[4] ? e[3:0] : 4'h0});
  endtask

  task automatic check_exports(input string req);
    for (int d = 0; d < NDEV; d++) begin
      chk(req, dev_en[d], m_act[d]);
      chk(req, dev_base[d*16 +: 16], m_base[d]);
    end
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [4:0] e;
    void'($urandom(32'd4242));
    m_idx = 0; m_dev = 0;
    for (int d = 0; d < NDEV; d++) begin m_act[d] = 0; m_base[d] = 0; end
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R8 reset state
    chk("R8 rdata", host_rdata, 8'h00);
    chk("R8 hit", rt_hit, 1'b0);
    check_exports("R8 exports");
    host_read(0, v); chk("R8 index", v, 8'h00);
    reg_check("R8 selector", 8'h07);

    // R1 index latch
    host_write(0, 8'h5A); host_read(0, v); chk("R1", v, 8'h5A);

    // R2, R3 read-only
    reg_write(8'h20, 8'h11); reg_check("R2", 8'h20);
    reg_write(8'h27, 8'h22); reg_check("R3", 8'h27);
    reg_check("R4 after ro writes", 8'h07);
    check_exports("R2 no side effect");

    // R4 selector
    reg_write(8'h07, 8'h0E); reg_check("R4 max", 8'h07);
    reg_write(8'h07, 8'h0F); reg_check("R4 ignore 0x0F", 8'h07);
    reg_write(8'h07, 8'hF3); reg_check("R4 ignore 0xF3", 8'h07);

    // R5, R6 banking
    reg_write(8'h07, 8'h03);
    reg_write(8'h30, 8'hFF); reg_check("R5 read", 8'h30);
    reg_write(8'h60, 8'h12); reg_write(8'h61, 8'h40);
    reg_check("R6 hi", 8'h60); reg_check("R6 lo", 8'h61);
    reg_write(8'h07, 8'h05);
    reg_check("R5 other dev", 8'h30); reg_check("R6 other dev", 8'h60);
    reg_write(8'h60, 8'h12); reg_write(8'h61, 8'h4C); reg_write(8'h30, 8'h01);
    check_exports("R10");

    // R7 unimplemented
    reg_check("R7 0x31", 8'h31); reg_check("R7 0xFF", 8'hFF); reg_check("R7 0x00", 8'h00);

    // R11 priority: devices 3 and 5 share window 0x124x
    probe("R11 lowest wins", 16'h124F);
    probe("R11 miss", 16'h1250);
    reg_write(8'h07, 8'h03); reg_write(8'h30, 8'h00);
    probe("R11 next owner", 16'h1240);
    probe("R11 inactive", 16'h1000);

    // R9 hold and host_cs low
    host_write(0, 8'h20); host_read(1, v);
    repeat (3) @(negedge clk);
    chk("R9 hold", host_rdata, 8'hE9);
    @(negedge clk); host_wr = 1; host_addr = 0; host_wdata = 8'h99;
    @(negedge clk); host_wr = 0;
    host_read(0, v); chk("R9 cs low ignored", v, 8'h20);

    // R12 same-cycle: dev 2 active at 0x0300, deactivate while probing
    reg_write(8'h07, 8'h02); reg_write(8'h60, 8'h03); reg_write(8'h61, 8'h00);
    reg_write(8'h30, 8'h01);
    host_write(0, 8'h30);
    e = exp_rt(16'h0305);
    @(negedge clk);
    host_cs = 1; host_wr = 1; host_addr = 1; host_wdata = 8'h00;
    rt_valid = 1; rt_addr = 16'h0305;
    @(negedge clk);
    host_cs = 0; host_wr = 0; rt_valid = 0;
    model_write(8'h00);
    chk("R12 old config", {rt_hit, rt_dev}, e);
    probe("R12 new config", 16'h0305);

    // random phase
    for (int n = 0; n < 400; n++) begin
      int op;
      op = $urandom_range(0, 5);
      case (op)
        0: begin
          logic [7:0] pick[8] = '{8'h07, 8'h20, 8'h27, 8'h30, 8'h60, 8'h61, 8'h31, 8'h00};
          host_write(0, pick[$urandom_range(0, 7)]);
        end
        1: host_write(1, 8'($urandom_range(0, 255)));
        2: host_write(1, 8'($urandom_range(0, 20)));
        3: begin host_read(1, v); chk("R5 R6 random read", v, exp_read(m_idx)); end
        4: begin
          int d = $urandom_range(0, NDEV - 1);
          probe("R11 random", m_base[d] ^ 16'($urandom_range(0, 31)));
        end
        default: begin host_read(0, v); chk("R1 random", v, m_idx); end
      endcase
    end
    check_exports("R10 final");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule